// File: doc/BRIEF.md
# Programmable Sample Timer and Averager

This block produces the internal sample-update tick for a sensor pipeline and smooths a signed sample stream with a boxcar filter that advances once per tick. The tick period comes from an 8-bit configuration byte. Its top bit picks one of two time bases, and its low seven bits give a multiplier. A fixed offset is then added. The period is counted in cycles of a reference clock, so the offset and both time bases are tick-count parameters. With the default parameters and an 8.192 MHz reference, a setting of 0x01 gives 3000 ticks, which is 366.21 µs.

The filter window is 2^M samples, where M comes from a 4-bit field of a second configuration word. The mean is formed by shifting a running sum instead of dividing it. Whenever the effective period byte or the effective M changes, the history, the sum and the output are cleared, and the period counter restarts. A one-cycle update strobe marks each new filtered value; downstream logic uses it to set its new-data flags. A mode output reports whether the current period setting is in the fast range or the normal range.

Top module: `sample_avg_top`

## Requirements
- R1: The update period in reference cycles is `base * NS + OFFSET_TICKS`. NS is `period_cfg_i[6:0]`. The base is `BASE_SLOW_TICKS` when `period_cfg_i[7]` is 1 and `BASE_FAST_TICKS` when it is 0. After reset or a flush, the first update comes exactly one period after the restarting edge.
- R2: A multiplier field NS of 0 acts as NS = 1.
- R3: `period_cfg_i[15:8]` and `avg_cfg_i[15:4]` have no effect. Changing them alters neither the period nor the output, and it does not clear the history.
- R4: `fast_o` is 1 exactly when `period_cfg_i[7:0]` is 0x07 or less.
- R5: On each update, `avg_o` is the sum of the last 2^M accepted samples, shifted right arithmetically by M, so the result rounds toward minus infinity. History slots not yet filled since the last flush count as zero. M is `avg_cfg_i[3:0]`.
- R6: An M field above `MAX_M` acts as `MAX_M`. Two settings that clamp to the same value are the same setting and cause no flush.
- R7: A change in `period_cfg_i[7:0]` or in the effective M clears the history and the sum, drives `avg_o` to 0 on the next cycle, and restarts the period count.
- R8: `upd_o` is high for exactly one cycle per period. It rises in the same cycle that `avg_o` takes its new value.
- R9: While `rst_ni` is low, `avg_o` and `upd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_cfg_i | input | 16 | Sample-period setting: bit 7 selects the time base, bits 6:0 hold the multiplier |
| avg_cfg_i | input | 16 | Averaging setting: bits 3:0 hold M |
| sample_i | input | SAMPLE_W | Signed raw sample, taken at each tick |
| avg_o | output | SAMPLE_W | Signed filtered sample |
| upd_o | output | 1 | One-cycle strobe marking a new filtered sample |
| fast_o | output | 1 | High when the period setting is in the fast range |

## Verification
The bench builds the block with `MAX_M` = 3, fast and slow bases of 3 and 5 ticks, and an offset of 2 ticks. With these values every period from the shortest (5 cycles) to a normal-range setting (26 cycles) can be checked on each update. The full window, including its fill-up phase and its wrap-around in the circular history, is reached within a few samples. M values of 9 and 15 reach the clamp, and both clamp to the same window. Negative samples exercise rounding toward minus infinity in the shifted mean.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef struct packed {
    logic       slow_base;
    logic [6:0] mult;
  } per_cfg_t;

  function automatic logic [6:0] mult_eff(input logic [6:0] m);
    return (m == 7'd0) ? 7'd1 : m;
  endfunction

  function automatic logic [3:0] clamp_m(input logic [3:0] m, input int unsigned max_m);
    return (32'(m) > max_m) ? 4'(max_m) : m;
  endfunction

endpackage

// File: rtl/sat_cfg_track.sv
module sat_cfg_track
  import sat_pkg::*;
#(
  parameter int unsigned MAX_M      = 8,
  parameter logic [7:0]  RST_PERIOD = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  per_lo_i,
  input  logic [3:0]  m_raw_i,
  output per_cfg_t    per_o,
  output logic [3:0]  m_o,
  output logic        flush_o,
  output logic        fast_o
);

  logic [7:0] per_q;
  logic [3:0] m_q;

  assign per_o  = per_cfg_t'(per_lo_i);
  assign m_o    = clamp_m(m_raw_i, MAX_M);
  assign fast_o = (per_lo_i < 8'd8);

  // any effective change restarts timing and filter
  assign flush_o = (per_lo_i != per_q) || (m_o != m_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= RST_PERIOD;
      m_q   <= 4'(MAX_M);
    end else begin
      per_q <= per_lo_i;
      m_q   <= m_o;
    end
  end

endmodule

// File: rtl/sat_period_gen.sv
module sat_period_gen
  import sat_pkg::*;
#(
  parameter int unsigned BASE_FAST_TICKS = 2000,
  parameter int unsigned BASE_SLOW_TICKS = 62000,
  parameter int unsigned OFFSET_TICKS    = 1000,
  localparam int unsigned MAX_BASE = (BASE_FAST_TICKS > BASE_SLOW_TICKS) ? BASE_FAST_TICKS : BASE_SLOW_TICKS,
  localparam int unsigned CNT_W    = $clog2(MAX_BASE * 127 + OFFSET_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  per_cfg_t         cfg_i,
  input  logic             flush_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] period_m1_o
);

  logic [CNT_W-1:0] base_t;
  logic [CNT_W-1:0] mult_w;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (BASE_FAST_TICKS == BASE_SLOW_TICKS) begin : g_one_base
      logic unused_sel;
      assign unused_sel = cfg_i.slow_base;
      assign base_t = CNT_W'(BASE_FAST_TICKS);
    end else begin : g_two_base
      assign base_t = cfg_i.slow_base ? CNT_W'(BASE_SLOW_TICKS) : CNT_W'(BASE_FAST_TICKS);
    end
  endgenerate

  assign mult_w      = CNT_W'(mult_eff(cfg_i.mult));
  assign period_m1_o = CNT_W'(base_t * mult_w + CNT_W'(OFFSET_TICKS) - CNT_W'(1));
  assign tick_o      = !flush_i && (cnt_q == period_m1_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (flush_i)              cnt_q <= '0;
    else if (cnt_q == period_m1_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> cnt_q <= period_m1_o);

  assert_tick_wraps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);

endmodule

// File: rtl/sat_boxcar.sv
module sat_boxcar #(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned MAX_M    = 8,
  localparam int unsigned DEPTH = 1 << MAX_M,
  localparam int unsigned PTR_W = MAX_M,
  localparam int unsigned SUM_W = SAMPLE_W + MAX_M + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       flush_i,
  input  logic [3:0]                 m_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [SAMPLE_W-1:0] avg_o,
  output logic                       upd_o
);

  logic signed [SAMPLE_W-1:0] hist [DEPTH];
  logic [PTR_W-1:0]           wr_ptr_q;
  logic [MAX_M:0]             fill_q;
  logic [MAX_M:0]             win;
  logic                       full;
  logic [PTR_W-1:0]           old_idx;
  logic signed [SUM_W-1:0]    sum_q, sum_nx, new_ext, old_ext;
  logic signed [SAMPLE_W-1:0] avg_d;

  assign win     = (MAX_M+1)'(1) << m_i;
  assign full    = (fill_q == win);
  // full window of DEPTH truncates to 0: oldest is the slot being overwritten
  assign old_idx = wr_ptr_q - win[PTR_W-1:0];
  assign new_ext = {{(SUM_W-SAMPLE_W){sample_i[SAMPLE_W-1]}}, sample_i};
  assign old_ext = {{(SUM_W-SAMPLE_W){hist[old_idx][SAMPLE_W-1]}}, hist[old_idx]};
  assign sum_nx  = sum_q + new_ext - (full ? old_ext : '0);
  assign avg_d   = SAMPLE_W'(sum_nx >>> m_i);

  always_ff @(posedge clk_i) begin
    if (tick_i && !flush_i) hist[wr_ptr_q] <= sample_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q    <= '0;
      fill_q   <= '0;
      wr_ptr_q <= '0;
      avg_o    <= '0;
      upd_o    <= 1'b0;
    end else if (flush_i) begin
      sum_q    <= '0;
      fill_q   <= '0;
      wr_ptr_q <= '0;
      avg_o    <= '0;
      upd_o    <= 1'b0;
    end else if (tick_i) begin
      sum_q    <= sum_nx;
      fill_q   <= full ? fill_q : fill_q + (MAX_M+1)'(1);
      wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      avg_o    <= avg_d;
      upd_o    <= 1'b1;
    end else begin
      upd_o    <= 1'b0;
    end
  end

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (sum_q == '0) && (avg_o == '0) && (fill_q == '0));

  assert_fill_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> fill_q <= win);

endmodule

// File: rtl/sample_avg_top.sv
module sample_avg_top
  import sat_pkg::*;
#(
  parameter int unsigned SAMPLE_W        = 14,
  parameter int unsigned MAX_M           = 8,
  parameter int unsigned BASE_FAST_TICKS = 2000,
  parameter int unsigned BASE_SLOW_TICKS = 62000,
  parameter int unsigned OFFSET_TICKS    = 1000,
  parameter logic [7:0]  RST_PERIOD      = 8'h01,
  localparam int unsigned MAX_BASE = (BASE_FAST_TICKS > BASE_SLOW_TICKS) ? BASE_FAST_TICKS : BASE_SLOW_TICKS,
  localparam int unsigned CNT_W    = $clog2(MAX_BASE * 127 + OFFSET_TICKS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [15:0]                period_cfg_i,
  input  logic [15:0]                avg_cfg_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [SAMPLE_W-1:0] avg_o,
  output logic                       upd_o,
  output logic                       fast_o
);

  per_cfg_t         per_cfg;
  logic [3:0]       m_eff;
  logic             flush;
  logic             tick;
  logic [CNT_W-1:0] period_m1;
  logic             unused_hi;

  assign unused_hi = ^{period_cfg_i[15:8], avg_cfg_i[15:4]};

  sat_cfg_track #(
    .MAX_M      (MAX_M),
    .RST_PERIOD (RST_PERIOD)
  ) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_lo_i (period_cfg_i[7:0]),
    .m_raw_i  (avg_cfg_i[3:0]),
    .per_o    (per_cfg),
    .m_o      (m_eff),
    .flush_o  (flush),
    .fast_o   (fast_o)
  );

  sat_period_gen #(
    .BASE_FAST_TICKS (BASE_FAST_TICKS),
    .BASE_SLOW_TICKS (BASE_SLOW_TICKS),
    .OFFSET_TICKS    (OFFSET_TICKS)
  ) u_period (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (per_cfg),
    .flush_i     (flush),
    .tick_o      (tick),
    .period_m1_o (period_m1)
  );

  sat_boxcar #(
    .SAMPLE_W (SAMPLE_W),
    .MAX_M    (MAX_M)
  ) u_avg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .flush_i  (flush),
    .m_i      (m_eff),
    .sample_i (sample_i),
    .avg_o    (avg_o),
    .upd_o    (upd_o)
  );

  assert_upd_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  assert_flush_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> !upd_o);

  assert_fast_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> period_m1 < CNT_W'(BASE_FAST_TICKS * 8 + OFFSET_TICKS - 1));

endmodule

// File: tb/sample_avg_top_tb_top.sv
module sample_avg_top_tb_top;

  localparam int SW = 14;
  localparam int MM = 3;
  localparam int BF = 3;
  localparam int BS = 5;
  localparam int OF = 2;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic                 rst_ni;
  logic [15:0]          per_cfg;
  logic [15:0]          avg_cfg;
  logic signed [SW-1:0] smp;
  logic signed [SW-1:0] avg;
  logic                 upd;
  logic                 fast;

  sample_avg_top #(
    .SAMPLE_W        (SW),
    .MAX_M           (MM),
    .BASE_FAST_TICKS (BF),
    .BASE_SLOW_TICKS (BS),
    .OFFSET_TICKS    (OF),
    .RST_PERIOD      (8'h01)
  ) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_cfg_i (per_cfg),
    .avg_cfg_i    (avg_cfg),
    .sample_i     (smp),
    .avg_o        (avg),
    .upd_o        (upd),
    .fast_o       (fast)
  );

  int    total = 0, bad = 0, cyc = 0, last_upd = 0, exp_per = 5, cur_m = MM;
  bit    done = 0;
  int    exp_val[$];
  string exp_tag[$];
  int    mdl[$];

  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int per_of(input logic [15:0] c);
    int ns = int'(c[6:0]);
    if (ns == 0) ns = 1;
    return (c[7] ? BS : BF) * ns + OF;
  endfunction

  function automatic int eff_m(input logic [15:0] a);
    int m = int'(a[3:0]);
    return (m > MM) ? MM : m;
  endfunction

  // driver: set sample, push model result, wait for the update
  task automatic step(input int s, input string tag);
    int w, sm;
    smp = SW'(s);
    mdl.push_back(s);
    if (mdl.size() > (1 << MM)) void'(mdl.pop_front());
    w  = 1 << cur_m;
    sm = 0;
    for (int i = 0; i < w; i++)
      if (mdl.size() - 1 - i >= 0) sm += mdl[mdl.size() - 1 - i];
    exp_val.push_back(sm >>> cur_m);
    exp_tag.push_back(tag);
    do @(negedge clk_i); while (!upd);
    @(negedge clk_i);
    chk(!upd, "R8 strobe one cycle", int'(upd), 0);
  endtask

  task automatic reconf(input logic [15:0] p, input logic [15:0] a);
    bit fl;
    @(negedge clk_i);
    fl = (p[7:0] != per_cfg[7:0]) || (eff_m(a) != eff_m(avg_cfg));
    per_cfg = p;
    avg_cfg = a;
    cur_m   = eff_m(a);
    exp_per = per_of(p);
    if (fl) begin
      mdl.delete();
      last_upd = cyc + 1;
    end
    @(negedge clk_i);
    if (fl) chk(avg == '0, "R7 flush clears output", int'(avg), 0);
    chk(fast == (p[7:0] < 8'd8), "R4 fast mode", int'(fast), int'(p[7:0] < 8'd8));
  endtask

  // monitor: compare each update against the scoreboard and the period
  always @(negedge clk_i) begin
    if (rst_ni && !done && upd) begin
      int    e;
      string t;
      if (exp_val.size() == 0) chk(1'b0, "R8 unexpected update", 1, 0);
      else begin
        e = exp_val.pop_front();
        t = exp_tag.pop_front();
        chk(int'(avg) == e, t, int'(avg), e);
      end
      chk(cyc - last_upd == exp_per, "R1 period", cyc - last_upd, exp_per);
      last_upd = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni  = 1'b0;
    per_cfg = 16'h0001;
    avg_cfg = 16'h0003;
    smp     = '0;
    repeat (3) @(negedge clk_i);
    chk(avg == '0, "R9 reset output", int'(avg), 0);
    chk(!upd, "R9 reset strobe", int'(upd), 0);
    chk(fast, "R4 fast at 0x01", int'(fast), 1);
    rst_ni   = 1'b1;
    last_upd = cyc;

    // window 8, fill-up then steady state
    step(100, "R5 fill w8");
    step(200, "R5 fill w8");
    step(-50, "R5 fill w8");
    step(300, "R5 fill w8");
    for (int i = 0; i < 7; i++) step(8, "R5 wrap w8");

    reconf(16'h0001, 16'h0002);
    step(7, "R5 w4");
    step(-9, "R5 w4 negative floor");
    step(1000, "R5 w4");
    step(-8192, "R5 w4 extreme");
    step(8191, "R5 w4 extreme");
    step(5, "R5 w4 wrap");

    reconf(16'h0000, 16'h0000);
    step(-3, "R2 ns0 pass");
    step(5, "R2 ns0 pass");

    reconf(16'h0082, 16'h0000);
    step(-1, "R1 slow base");
    step(2, "R1 slow base");

    reconf(16'hFF08, 16'h0001);
    step(10, "R1 normal w2");
    step(-13, "R1 normal w2");

    reconf(16'h5508, 16'h0031);
    step(4, "R3 upper bits ignored");
    step(6, "R3 upper bits ignored");

    reconf(16'h0007, 16'h0009);
    for (int i = 1; i <= 10; i++) step(-i, "R6 clamp w8");

    reconf(16'h0007, 16'h000F);
    step(-100, "R6 same clamp no flush");
    step(50, "R6 same clamp no flush");

    done = 1;
    chk(exp_val.size() == 0, "R8 missing updates", exp_val.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule